// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm and Periodic Interrupts

The block keeps wall-clock time for a system: a day counter plus hour, minute and second counters advance once per second. A prescaler derives that second from a low-frequency reference. The reference arrives as a one-cycle strobe, `ref_tick`, in the system clock domain, and its rate is picked from three values by a control field. The same prescaler also produces sub-second ticks at power-of-two rates from 2 Hz to 512 Hz. Each event kind has its own status bit, and every bit is masked by an enable register before feeding a single registered interrupt line.

Software reaches the block through a 16-bit register port. There are separate read and write strobes and a byte address, and read data is returned one cycle after the strobe. Status bits are cleared by writing ones to them. An alarm is set by loading a day, hour, minute and second. The alarm bit rises once, when the time reaches that value at a second boundary.

Top module: `rtc_calendar`

## Requirements
- R1: Byte offsets: 0x00 hour/minute (hour in bits 12:8, minute in bits 5:0), 0x04 seconds (bits 5:0), 0x08 alarm hour/minute, 0x0C alarm seconds, 0x10 control, 0x14 status, 0x18 enable, 0x20 day, 0x24 alarm day; `rd_data` is updated on the edge that samples `rd_en` and holds the value the register had before that edge.
- R2: Control bit 7 runs the clock and bits 6:5 choose the reference rate; both read back as written, and all other control bits read 0.
- R3: A second boundary occurs every RATE reference strobes, where RATE is `RATE0` for select 00 or 11, `RATE1` for 01 and `RATE2` for 10 (defaults 32768, 32000, 38400); the seconds count changes two edges after the strobe that completes the second.
- R4: A write to the seconds register, or to control, restarts the sub-second phase, so the next boundary falls RATE strobes after that write.
- R5: Seconds and minutes wrap 59 to 0 with carry, hours wrap 23 to 0, and an hour wrap increments the day counter.
- R6: With control bit 7 at 0, the time counters and the prescaler hold and no status bit sets.
- R7: Status bit positions: 2 alarm, 4 once per second, 7 at 2 Hz, 8+j at 2^(j+2) Hz for j = 0..7 (bit 15 at 512 Hz); all tick bits fire together at a second boundary, and the 2^(j+2) Hz bit follows every 2^(8-j)-th sub-second step.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged; writing 0xFFFF clears every bit not being set in that cycle.
- R9: A status bit set in the same cycle as a clear write to it stays 1.
- R10: The alarm bit sets one edge after a second boundary at which day, hour, minute and second all equal the alarm fields, and only once for that match.
- R11: `irq` goes high one edge after any bit of (status AND enable) is 1 and low one edge after none is; status bits set whatever the enable.
- R12: Status bit 0 and all other unimplemented status bits read 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe at the reference rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench counts system edges from each seconds write. For the strobe that completes a second, the tick register loads on that edge. The counters move one edge later, the once-per-second and tap bits set on that same edge, the alarm bit sets one edge after the counters, and `irq` follows its status bit by one more edge. Every read is issued at a computed edge number so that it lands one cycle before and one cycle after each of these updates. The expected data for each read sits in a scoreboard queue and is compared when `rd_data` settles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] OFF_HM   = 8'h00;
  localparam logic [7:0] OFF_SEC  = 8'h04;
  localparam logic [7:0] OFF_AHM  = 8'h08;
  localparam logic [7:0] OFF_ASEC = 8'h0C;
  localparam logic [7:0] OFF_CTL  = 8'h10;
  localparam logic [7:0] OFF_STAT = 8'h14;
  localparam logic [7:0] OFF_IEN  = 8'h18;
  localparam logic [7:0] OFF_DAY  = 8'h20;
  localparam logic [7:0] OFF_ADAY = 8'h24;

  localparam int BIT_ALARM = 2;
  localparam int BIT_SEC   = 4;
  localparam int BIT_HALF  = 7;
  localparam int BIT_TAP0  = 8;

  localparam logic [15:0] IMPL_MASK = 16'hFF94;

  // sub-second steps per second are 2**SUB_W; taps need SUB_W = 10
  localparam int SUB_W = 10;

  typedef struct packed {
    logic       one_hz;
    logic       two_hz;
    logic [7:0] tap;
  } tick_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int RATE0 = 32768,
  parameter int RATE1 = 32000,
  parameter int RATE2 = 38400,
  parameter int ACC_W = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       ref_tick,
  input  logic       restart,
  input  logic [1:0] sel,
  output tick_t      tick
);
  localparam logic [ACC_W-1:0] STEP = ACC_W'(2 ** SUB_W);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] rate;
  logic [ACC_W-1:0] sum;
  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] sub_nx;
  tick_t            tick_nx;

  always_comb begin
    case (sel)
      2'b01:   rate = ACC_W'(RATE1);
      2'b10:   rate = ACC_W'(RATE2);
      default: rate = ACC_W'(RATE0);
    endcase
  end

  assign sum    = acc + STEP;
  assign sub_nx = sub + 1'b1;

  assign tick_nx.one_hz = (sub_nx == '0);
  assign tick_nx.two_hz = (sub_nx[SUB_W-2:0] == '0);
  for (genvar j = 0; j < 8; j++) begin : g_tap
    assign tick_nx.tap[j] = (sub_nx[7-j:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      sub  <= '0;
      tick <= '0;
    end else begin
      tick <= '0;
      if (restart) begin
        acc <= '0;
        sub <= '0;
      end else if (run && ref_tick) begin
        if (sum >= rate) begin
          acc  <= sum - rate;
          sub  <= sub_nx;
          tick <= tick_nx;
        end else begin
          acc <= sum;
        end
      end
    end
  end

  AST_TAPS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    tick.one_hz |-> (tick.two_hz && (&tick.tap))); // R7
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> ($stable(sub) && $stable(acc))); // R6
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep #(
  parameter int DAY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             wr_hm,
  input  logic             wr_sec,
  input  logic             wr_day,
  input  logic             wr_ahm,
  input  logic             wr_asec,
  input  logic             wr_aday,
  input  logic [15:0]      wdata,
  output logic [5:0]       sec,
  output logic [5:0]       min,
  output logic [4:0]       hour,
  output logic [DAY_W-1:0] day,
  output logic [5:0]       a_sec,
  output logic [5:0]       a_min,
  output logic [4:0]       a_hour,
  output logic [DAY_W-1:0] a_day,
  output logic             alarm_hit
);
  logic [5:0]       sec_n, min_n;
  logic [4:0]       hour_n;
  logic [DAY_W-1:0] day_n;
  logic             stepped;

  always_comb begin
    sec_n  = sec;
    min_n  = min;
    hour_n = hour;
    day_n  = day;
    if (step) begin
      if (sec >= 6'd59) begin
        sec_n = '0;
        if (min >= 6'd59) begin
          min_n = '0;
          if (hour >= 5'd23) begin
            hour_n = '0;
            day_n  = day + 1'b1;
          end else begin
            hour_n = hour + 1'b1;
          end
        end else begin
          min_n = min + 1'b1;
        end
      end else begin
        sec_n = sec + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec     <= '0;
      min     <= '0;
      hour    <= '0;
      day     <= '0;
      a_sec   <= '0;
      a_min   <= '0;
      a_hour  <= '0;
      a_day   <= '0;
      stepped <= 1'b0;
    end else begin
      sec     <= wr_sec ? wdata[5:0] : sec_n;
      min     <= wr_hm ? wdata[5:0] : min_n;
      hour    <= wr_hm ? wdata[12:8] : hour_n;
      day     <= wr_day ? wdata[DAY_W-1:0] : day_n;
      stepped <= step;
      if (wr_asec) a_sec <= wdata[5:0];
      if (wr_ahm) begin
        a_min  <= wdata[5:0];
        a_hour <= wdata[12:8];
      end
      if (wr_aday) a_day <= wdata[DAY_W-1:0];
    end
  end

  // compared once, in the cycle after the counters advance
  assign alarm_hit = stepped && (sec == a_sec) && (min == a_min) &&
                     (hour == a_hour) && (day == a_day);

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_sec && sec == 6'd59) |=> (sec == 6'd0)); // R5
  AST_DAY_CARRY: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_sec && !wr_hm && !wr_day && sec == 6'd59 && min == 6'd59 && hour >= 5'd23)
    |=> (day == $past(day) + 1'b1 && hour == 5'd0)); // R5
  AST_ALARM_SINGLE: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |=> !alarm_hit); // R10
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
  parameter logic [15:0] IMPL = 16'hFF94
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] set_vec,
  input  logic        wr_stat,
  input  logic        wr_ien,
  input  logic [15:0] wdata,
  output logic [15:0] status,
  output logic [15:0] enable,
  output logic        irq
);
  logic [15:0] clr_vec;

  assign clr_vec = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= ((status & ~clr_vec) | set_vec) & IMPL;
      if (wr_ien) enable <= wdata & IMPL;
      irq <= |(status & enable);
    end
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec & IMPL)) == $past(set_vec & IMPL))); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((status & enable) == '0) |=> !irq); // R11
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((status & ~IMPL) == '0)); // R12
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int RATE0  = 32768,
  parameter int RATE1  = 32000,
  parameter int RATE2  = 38400,
  parameter int DAY_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rd_data,
  output logic              irq
);
  localparam int RMAX01 = (RATE0 > RATE1) ? RATE0 : RATE1;
  localparam int RMAX   = (RMAX01 > RATE2) ? RMAX01 : RATE2;
  localparam int ACC_W  = $clog2(RMAX) + 2;

  logic             run;
  logic [1:0]       sel;
  logic             wr_hm, wr_sec, wr_ahm, wr_asec, wr_ctl, wr_stat, wr_ien, wr_day, wr_aday;
  tick_t            tick, tick_g;
  logic [5:0]       sec, min, a_sec, a_min;
  logic [4:0]       hour, a_hour;
  logic [DAY_W-1:0] day, a_day;
  logic             alarm_hit;
  logic [15:0]      set_vec, status, enable, rd_nx;

  assign wr_hm   = wr_en && (addr == ADDR_W'(OFF_HM));
  assign wr_sec  = wr_en && (addr == ADDR_W'(OFF_SEC));
  assign wr_ahm  = wr_en && (addr == ADDR_W'(OFF_AHM));
  assign wr_asec = wr_en && (addr == ADDR_W'(OFF_ASEC));
  assign wr_ctl  = wr_en && (addr == ADDR_W'(OFF_CTL));
  assign wr_stat = wr_en && (addr == ADDR_W'(OFF_STAT));
  assign wr_ien  = wr_en && (addr == ADDR_W'(OFF_IEN));
  assign wr_day  = wr_en && (addr == ADDR_W'(OFF_DAY));
  assign wr_aday = wr_en && (addr == ADDR_W'(OFF_ADAY));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      sel <= 2'b00;
    end else if (wr_ctl) begin
      run <= wdata[7];
      sel <= wdata[6:5];
    end
  end

  rtc_prescaler #(
    .RATE0(RATE0), .RATE1(RATE1), .RATE2(RATE2), .ACC_W(ACC_W)
  ) u_pre (
    .clk(clk), .rst(rst), .run(run), .ref_tick(ref_tick),
    .restart(wr_sec || wr_ctl), .sel(sel), .tick(tick)
  );

  assign tick_g = run ? tick : '0;

  rtc_timekeep #(.DAY_W(DAY_W)) u_time (
    .clk(clk), .rst(rst), .step(tick_g.one_hz),
    .wr_hm(wr_hm), .wr_sec(wr_sec), .wr_day(wr_day),
    .wr_ahm(wr_ahm), .wr_asec(wr_asec), .wr_aday(wr_aday),
    .wdata(wdata),
    .sec(sec), .min(min), .hour(hour), .day(day),
    .a_sec(a_sec), .a_min(a_min), .a_hour(a_hour), .a_day(a_day),
    .alarm_hit(alarm_hit)
  );

  always_comb begin
    set_vec = '0;
    set_vec[BIT_ALARM] = alarm_hit;
    set_vec[BIT_SEC]   = tick_g.one_hz;
    set_vec[BIT_HALF]  = tick_g.two_hz;
    set_vec[BIT_TAP0 +: 8] = tick_g.tap;
  end

  rtc_irq #(.IMPL(IMPL_MASK)) u_irq (
    .clk(clk), .rst(rst), .set_vec(set_vec), .wr_stat(wr_stat),
    .wr_ien(wr_ien), .wdata(wdata), .status(status), .enable(enable), .irq(irq)
  );

  always_comb begin
    rd_nx = '0;
    if (addr == ADDR_W'(OFF_HM))        rd_nx = {3'b0, hour, 2'b0, min};
    else if (addr == ADDR_W'(OFF_SEC))  rd_nx = {10'b0, sec};
    else if (addr == ADDR_W'(OFF_AHM))  rd_nx = {3'b0, a_hour, 2'b0, a_min};
    else if (addr == ADDR_W'(OFF_ASEC)) rd_nx = {10'b0, a_sec};
    else if (addr == ADDR_W'(OFF_CTL))  rd_nx = {8'b0, run, sel, 5'b0};
    else if (addr == ADDR_W'(OFF_STAT)) rd_nx = status;
    else if (addr == ADDR_W'(OFF_IEN))  rd_nx = enable;
    else if (addr == ADDR_W'(OFF_DAY))  rd_nx = 16'(day);
    else if (addr == ADDR_W'(OFF_ADAY)) rd_nx = 16'(a_day);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_nx;
  end

  AST_RUN_READBACK: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && wdata[7]) |=> run); // R2
endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam logic [5:0] A_HM = 6'h00, A_SEC = 6'h04, A_AHM = 6'h08, A_ASEC = 6'h0C,
                         A_CTL = 6'h10, A_ST = 6'h14, A_IEN = 6'h18, A_GAP = 6'h1C,
                         A_DAY = 6'h20, A_ADAY = 6'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_data;
  logic        irq;

  int n_vec  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int edge_at = 0;
  logic rd_seen = 1'b0;

  logic [15:0] q_exp[$];
  logic [15:0] q_msk[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  rtc_calendar #(.RATE0(1024), .RATE1(2048), .RATE2(1536)) u0 (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq)
  );

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= rd_en;
  end

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen) begin
      n_vec++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL read with empty scoreboard: actual %h expected none", rd_data);
      end else begin
        logic [15:0] e, m;
        string t;
        e = q_exp.pop_front();
        m = q_msk.pop_front();
        t = q_tag.pop_front();
        if ((rd_data & m) !== (e & m)) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h (mask %h) at edge %0d", t, rd_data, e, m, cyc);
        end
      end
    end
  end

  task automatic idle_to(input int t);
    while (cyc + 1 < t) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    edge_at = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input logic [15:0] m, input string t);
    q_exp.push_back(e); q_msk.push_back(m); q_tag.push_back(t);
    addr = a; rd_en = 1'b1;
    edge_at = cyc + 1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_vec++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq: actual %b expected %b at edge %0d", t, irq, e, cyc);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(A_CTL, 16'h0000, 16'hFFFF, "R2 reset control");
    rd(A_ST,  16'h0000, 16'hFFFF, "R12 reset status");
    rd(A_SEC, 16'h0000, 16'hFFFF, "R1 reset seconds");
    rd(A_HM,  16'h0000, 16'hFFFF, "R1 reset hour/minute");
    chk_irq(1'b0, "R11 reset");

    wr(A_CTL, 16'h0080);
    rd(A_CTL, 16'h0080, 16'hFFFF, "R2 enable readback");
    rd(A_GAP, 16'h0000, 16'hFFFF, "R12 unmapped offset");
    wr(A_HM, 16'h0A2D);
    rd(A_HM, 16'h0A2D, 16'hFFFF, "R1 hour/minute packing");

    // R4: second write restarts the phase
    wr(A_SEC, 16'd7); s = edge_at;
    idle_to(s + 600);
    wr(A_SEC, 16'd7); s = edge_at;
    idle_to(s + 1025);
    rd(A_SEC, 16'd7, 16'hFFFF, "R4 before boundary");
    rd(A_SEC, 16'd8, 16'hFFFF, "R3 R4 after boundary");

    // R7 / R9 / R8: sub-second taps and clear behaviour
    wr(A_SEC, 16'd3); s = edge_at;
    idle_to(s + 3);
    wr(A_ST, 16'hFFFF);
    rd(A_ST, 16'h8000, 16'hFFFF, "R9 set during clear survives");
    rd(A_ST, 16'h8000, 16'hFFFF, "R7 no tap on odd step");
    rd(A_ST, 16'hC000, 16'hFFFF, "R7 256 Hz tap on fourth step");
    idle_to(s + 8);
    wr(A_ST, 16'hFFFF);
    rd(A_ST, 16'h0000, 16'hFFFF, "R8 clear all");
    rd(A_ST, 16'hE000, 16'hFFFF, "R7 128 Hz tap on eighth step");

    // R5 / R10 / R11: rollover into a new day, alarm at 1 second past midnight
    wr(A_IEN, 16'h0004);
    wr(A_ADAY, 16'd6);
    wr(A_AHM, 16'h0000);
    wr(A_ASEC, 16'd1);
    wr(A_DAY, 16'd5);
    wr(A_HM, 16'h173B);
    wr(A_SEC, 16'd59); s = edge_at;
    idle_to(s + 1026);
    rd(A_DAY, 16'd6, 16'hFFFF, "R5 day carry");
    rd(A_HM, 16'h0000, 16'hFFFF, "R5 hour and minute wrap");
    rd(A_SEC, 16'h0000, 16'hFFFF, "R5 seconds wrap");
    idle_to(s + 2050);
    rd(A_ST, 16'h0000, 16'h0004, "R10 alarm not yet");
    chk_irq(1'b0, "R11 before alarm");
    rd(A_ST, 16'h0004, 16'h0004, "R10 alarm set");
    chk_irq(1'b1, "R11 alarm enabled");
    wr(A_ST, 16'h0004);
    wr(A_ST, 16'h0000);
    chk_irq(1'b0, "R11 pending but disabled");
    rd(A_ST, 16'h0010, 16'h0014, "R8 zero write keeps bit");
    idle_to(s + 2056);
    wr(A_ST, 16'hFFFF);
    rd(A_ST, 16'h0000, 16'hFFFF, "R8 all ones clears");
    idle_to(s + 2900);
    rd(A_ST, 16'h0000, 16'h0004, "R10 alarm once");

    // R3: other reference rates
    wr(A_CTL, 16'h00A0);
    rd(A_CTL, 16'h00A0, 16'hFFFF, "R2 select 01");
    wr(A_SEC, 16'd10); s = edge_at;
    idle_to(s + 2049);
    rd(A_SEC, 16'd10, 16'hFFFF, "R3 rate1 before");
    rd(A_SEC, 16'd11, 16'hFFFF, "R3 rate1 after");
    wr(A_CTL, 16'h00C0);
    rd(A_CTL, 16'h00C0, 16'hFFFF, "R2 select 10");
    wr(A_SEC, 16'd20); s = edge_at;
    idle_to(s + 1537);
    rd(A_SEC, 16'd20, 16'hFFFF, "R3 rate2 before");
    rd(A_SEC, 16'd21, 16'hFFFF, "R3 rate2 after");
    wr(A_CTL, 16'h00E0);
    rd(A_CTL, 16'h00E0, 16'hFFFF, "R2 select 11");
    wr(A_SEC, 16'd30); s = edge_at;
    idle_to(s + 1025);
    rd(A_SEC, 16'd30, 16'hFFFF, "R3 select 11 before");
    rd(A_SEC, 16'd31, 16'hFFFF, "R3 select 11 after");

    // R6: stopped clock holds
    wr(A_CTL, 16'h0000); s = edge_at;
    wr(A_SEC, 16'd40);
    idle_to(s + 5);
    wr(A_ST, 16'hFFFF);
    idle_to(s + 3000);
    rd(A_SEC, 16'd40, 16'hFFFF, "R6 seconds hold");
    rd(A_ST, 16'h0000, 16'hFFFF, "R6 no ticks");
    rd(A_CTL, 16'h0000, 16'hFFFF, "R2 run cleared");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule